// File: doc/BRIEF.md
# Ring-Oscillator Entropy Byte Collector

This block turns the outputs of a bank of free-running ring oscillators (128 rings of three inverters each by default) into a stream of random bytes. The rings run from a shared enable that the block drives. Their outputs arrive asynchronously and are folded by XOR into one raw bit. That bit crosses into the sampling clock domain (25 MHz in the intended system) through a two-flop synchronizer.

Each byte bit is the XOR of sixteen consecutive samples, so one byte is formed every 128 sample clocks. At 25 MHz that is about 195 kB/s. Finished bytes are offered on a valid/ready interface, for example to a session-identifier register or a nonce source.

The rings start from an unknown state, so the first byte formed after each enable is thrown away. A byte on offer is held until it is taken. If a new byte finishes while the previous one is still waiting, the new byte is lost.

Top module: `entropy_byte_collector`

## Requirements
- R1: `ring_en_o` equals `en_i`. After reset `out_valid_o` is 0 and `out_byte_o` is 0.
- R2: The raw bit is the XOR of all `ring_i` bits and passes through two synchronizer stages. The sample folded at enabled clock edge n (edges numbered from 0 after `en_i` rises) is the XOR of `ring_i` at enabled edge n-2, and is 0 for n below 2.
- R3: Enabled edges are split into groups of 16, and the samples in each group are XOR-ed into one bit. Eight groups make a byte, and the earliest group goes to bit 7. Byte k covers edges 128k to 128k+127 and is complete after edge 128k+127.
- R4: Byte 0 of every enable period is discarded. `out_valid_o` stays 0 until after enabled edge 255, when byte 1 is offered.
- R5: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_byte_o` and `out_valid_o` hold. An edge that sees `out_valid_o` and `out_ready_i` both 1 accepts the byte and clears `out_valid_o`, unless R7 applies.
- R6: A byte that completes while a held byte is not being accepted at that same edge is dropped, and the held byte is kept.
- R7: When a byte completes on the same edge that accepts the held byte, the new byte is loaded and `out_valid_o` stays 1.
- R8: An edge with `en_i` at 0 clears the synchronizer, the grouping counters, `out_valid_o` and `out_byte_o`. The next enable period again discards its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Collector and ring enable |
| ring_i | input | N_RINGS | Raw ring-oscillator outputs |
| ring_en_o | output | 1 | Enable driven to all rings |
| out_valid_o | output | 1 | A random byte is on offer |
| out_ready_i | input | 1 | Consumer takes the offered byte |
| out_byte_o | output | BYTE_W | Offered random byte |

## Verification
Byte completion and byte acceptance can fall on the same clock edge. The bench makes them meet by holding `out_ready_i` low while byte 1 waits, then raising it just before the edge that completes byte 2. The expected result is that byte 2 is loaded and `out_valid_o` stays high. A neighbouring scenario keeps `out_ready_i` low through that edge and confirms that byte 2 is dropped, byte 1 is kept, and byte 3 follows. Expected bytes are computed from a record of the ring parity the bench drove at each enabled edge.

// File: rtl/entropy_pkg.sv
package entropy_pkg;
    typedef enum logic {
        PH_WARMUP = 1'b0,
        PH_LIVE   = 1'b1
    } phase_e;
endpackage

// File: rtl/entropy_xor_fold.sv
module entropy_xor_fold #(
    parameter int unsigned N_RINGS = 128,
    parameter int unsigned CHUNK   = 8
) (
    input  logic [N_RINGS-1:0] ring_i,
    output logic               parity_o
);
    localparam int unsigned N_CHUNKS = N_RINGS / CHUNK;

    logic [N_CHUNKS-1:0] part;

    // first level: parity of each slice of rings
    generate
        for (genvar g = 0; g < N_CHUNKS; g++) begin : g_chunk
            assign part[g] = ^ring_i[g*CHUNK +: CHUNK];
        end
    endgenerate

    assign parity_o = ^part;
endmodule

// File: rtl/entropy_sync.sv
module entropy_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = '0;
        end else begin
            st_d.s1 = d_i;
            st_d.s2 = st_q.s1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/entropy_packer.sv
module entropy_packer #(
    parameter int unsigned DECIM  = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              sample_i,
    output logic              done_o,
    output logic [BYTE_W-1:0] byte_o
);
    localparam int unsigned DEC_W = $clog2(DECIM);
    localparam int unsigned GRP_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [DEC_W-1:0]  slot;
        logic [GRP_W-1:0]  grp;
        logic              acc;
        logic [BYTE_W-1:0] shreg;
    } pack_t;

    pack_t st_d, st_q;
    logic  folded, group_end, last_grp;

    assign folded    = st_q.acc ^ sample_i;
    assign group_end = (st_q.slot == DEC_W'(DECIM - 1));
    assign last_grp  = (st_q.grp == GRP_W'(BYTE_W - 1));
    assign done_o    = en_i && group_end && last_grp;
    assign byte_o    = {st_q.shreg[BYTE_W-2:0], folded};

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = '0;
        end else if (group_end) begin
            st_d.slot  = '0;
            st_d.acc   = 1'b0;
            st_d.shreg = {st_q.shreg[BYTE_W-2:0], folded};
            st_d.grp   = last_grp ? '0 : st_q.grp + 1'b1;
        end else begin
            st_d.slot = st_q.slot + 1'b1;
            st_d.acc  = folded;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/entropy_byte_collector.sv
module entropy_byte_collector #(
    parameter int unsigned N_RINGS = 128,
    parameter int unsigned CHUNK   = 8,
    parameter int unsigned DECIM   = 16,
    parameter int unsigned BYTE_W  = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic [N_RINGS-1:0] ring_i,
    output logic               ring_en_o,
    output logic               out_valid_o,
    input  logic               out_ready_i,
    output logic [BYTE_W-1:0]  out_byte_o
);
    import entropy_pkg::*;

    typedef struct packed {
        phase_e            phase;
        logic              valid;
        logic [BYTE_W-1:0] data;
    } out_t;

    out_t              st_d, st_q;
    logic              raw_bit, sample;
    logic              pk_done;
    logic [BYTE_W-1:0] pk_byte;

    assign ring_en_o = en_i;

    entropy_xor_fold #(.N_RINGS(N_RINGS), .CHUNK(CHUNK)) u_fold (
        .ring_i   (ring_i),
        .parity_o (raw_bit)
    );

    entropy_sync u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .d_i    (raw_bit),
        .q_o    (sample)
    );

    entropy_packer #(.DECIM(DECIM), .BYTE_W(BYTE_W)) u_pack (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (en_i),
        .sample_i (sample),
        .done_o   (pk_done),
        .byte_o   (pk_byte)
    );

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = '{phase: PH_WARMUP, valid: 1'b0, data: '0};
        end else begin
            if (st_q.valid && out_ready_i) st_d.valid = 1'b0;
            if (pk_done) begin
                if (st_q.phase == PH_WARMUP) begin
                    st_d.phase = PH_LIVE;
                end else if (!st_q.valid || out_ready_i) begin
                    st_d.data  = pk_byte;
                    st_d.valid = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{phase: PH_WARMUP, valid: 1'b0, data: '0};
        else         st_q <= st_d;
    end

    assign out_valid_o = st_q.valid;
    assign out_byte_o  = st_q.data;
endmodule

// File: rtl/entropy_byte_collector_chk.sv
module entropy_byte_collector_chk #(
    parameter int unsigned DECIM  = 16,
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              en_i,
    input logic              out_valid_o,
    input logic              out_ready_i,
    input logic [BYTE_W-1:0] out_byte_o
);
    localparam int unsigned SLOTS = DECIM * BYTE_W;

    logic [31:0] run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   run_q <= '0;
        else if (en_i) run_q <= run_q + 32'd1;
        else           run_q <= '0;
    end

    // R4
    warmup_discard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> (run_q >= 2 * SLOTS));

    // R3
    byte_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(out_valid_o) |-> ((run_q % SLOTS) == 0));

    // R5
    hold_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ready_i && en_i) |=> (out_valid_o && $stable(out_byte_o)));

    // R7
    accept_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && out_ready_i) |=> (!out_valid_o || ((run_q % SLOTS) == 0)));

    // R8
    disable_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!out_valid_o && out_byte_o == '0));
endmodule

bind entropy_byte_collector entropy_byte_collector_chk #(
    .DECIM(DECIM), .BYTE_W(BYTE_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_byte_o  (out_byte_o)
);

// File: tb/entropy_byte_collector_test.sv
module entropy_byte_collector_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_RINGS    = 128;
    localparam int DECIM      = 16;
    localparam int BYTE_W     = 8;
    localparam int SLOTS      = DECIM * BYTE_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               en = 1'b0;
    logic               ready = 1'b0;
    logic [N_RINGS-1:0] ring = '0;
    logic               ring_en;
    logic               valid;
    logic [BYTE_W-1:0]  data;

    int   compared = 0;
    int   mismatched = 0;
    int   en_edges = 0;
    int   mode = 0;
    logic xs [0:4095];
    logic [31:0] lfsr_a = 32'h1234_5678;
    logic [31:0] lfsr_b = 32'hCAFE_0B0E;

    entropy_byte_collector uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .en_i        (en),
        .ring_i      (ring),
        .ring_en_o   (ring_en),
        .out_valid_o (valid),
        .out_ready_i (ready),
        .out_byte_o  (data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ring stimulus, changed at the falling edge, parity recorded per enabled edge
    initial begin
        forever begin
            @(negedge clk);
            lfsr_a = {lfsr_a[30:0], 1'b0} ^ (lfsr_a[31] ? 32'h04C1_1DB7 : 32'h0);
            lfsr_b = {lfsr_b[30:0], 1'b0} ^ (lfsr_b[31] ? 32'h8020_0003 : 32'h0);
            if (mode == 0) ring = {lfsr_b, lfsr_b, lfsr_b, lfsr_a};
            else           ring = (en_edges % 16 == 0) ? {1'b1, 127'b0} : '0;
            if (en) xs[en_edges] = ^ring;
        end
    end

    task automatic tick();
        @(posedge clk);
        if (en) en_edges++;
        else    en_edges = 0;
        #1;
    endtask

    task automatic run_to(input int n);
        while (en_edges < n) tick();
    endtask

    function automatic logic [7:0] exp_byte(input int k);
        logic [7:0] b = '0;
        for (int g = 0; g < BYTE_W; g++) begin
            logic p = 1'b0;
            for (int j = 0; j < DECIM; j++) begin
                int m = SLOTS * k + DECIM * g + j - 2;
                if (m >= 0) p ^= xs[m];
            end
            b[7 - g] = p;
        end
        return b;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        compared++;
        if (act !== expv) begin
            mismatched++;
            $display("FAIL %s: actual=%0h expected=%0h (edge %0d)", req, act, expv, en_edges);
        end
    endtask

    task automatic start_session(input int md, input logic rdy);
        en = 1'b0;
        ready = rdy;
        mode = md;
        tick();
        tick();
        en = 1'b1;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        check("R1 reset valid", 32'(valid), 0);
        check("R1 reset byte", 32'(data), 0);
        check("R1 ring enable off", 32'(ring_en), 0);
    endtask

    task automatic test_stream();
        start_session(0, 1'b1);
        check("R1 ring enable on", 32'(ring_en), 1);
        run_to(SLOTS);
        check("R4 first byte discarded", 32'(valid), 0);
        run_to(2 * SLOTS - 1);
        check("R4 no byte before edge 255", 32'(valid), 0);
        run_to(2 * SLOTS);
        check("R3 byte 1 valid", 32'(valid), 1);
        check("R2 R3 byte 1 value", 32'(data), 32'(exp_byte(1)));
        tick();
        check("R5 accept clears valid", 32'(valid), 0);
        run_to(3 * SLOTS);
        check("R3 byte 2 value", 32'(data), 32'(exp_byte(2)));
    endtask

    task automatic test_hold();
        start_session(0, 1'b0);
        run_to(2 * SLOTS);
        check("R5 byte 1 offered", 32'(data), 32'(exp_byte(1)));
        run_to(3 * SLOTS - 1);
        check("R5 held valid", 32'(valid), 1);
        check("R5 held byte", 32'(data), 32'(exp_byte(1)));
        run_to(3 * SLOTS);
        check("R6 byte 2 dropped, byte 1 kept", 32'(data), 32'(exp_byte(1)));
        ready = 1'b1;
        tick();
        check("R5 accept after hold", 32'(valid), 0);
        ready = 1'b0;
        run_to(4 * SLOTS);
        check("R6 byte 3 follows", 32'(data), 32'(exp_byte(3)));
        check("R6 byte 3 valid", 32'(valid), 1);
    endtask

    task automatic test_same_edge();
        start_session(1, 1'b0);
        run_to(3 * SLOTS - 1);
        check("R7 byte 1 waiting", 32'(data), 32'(exp_byte(1)));
        ready = 1'b1;
        tick();
        check("R7 valid kept on reload", 32'(valid), 1);
        check("R7 byte 2 loaded", 32'(data), 32'(exp_byte(2)));
        tick();
        check("R7 reloaded byte accepted", 32'(valid), 0);
        ready = 1'b0;
    endtask

    task automatic test_disable();
        start_session(0, 1'b0);
        run_to(2 * SLOTS);
        check("R8 byte before disable", 32'(valid), 1);
        en = 1'b0;
        check("R1 ring enable follows", 32'(ring_en), 0);
        tick();
        check("R8 valid cleared", 32'(valid), 0);
        check("R8 byte cleared", 32'(data), 0);
        en = 1'b1;
        run_to(SLOTS);
        check("R8 R4 discard re-armed", 32'(valid), 0);
        run_to(2 * SLOTS);
        check("R8 fresh byte 1", 32'(data), 32'(exp_byte(1)));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        mismatched++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        test_reset();
        test_stream();
        test_hold();
        test_same_edge();
        test_disable();
        summary();
        $finish;
    end
endmodule